// File: doc/BRIEF.md
# Skip-Sequence Three-Bit State Counter

This block is a synchronous three-bit counter whose value walks a fixed, non-binary ring: 0, 3, 5, 7, 6, and then 0 again. It never uses an adder. Each state bit sits in its own JK storage stage. A next-state function gives the target value, and an excitation stage turns each pair of current and target bits into the J and K inputs of that stage.

The values 1, 2 and 4 are outside the ring. If the register ever holds one of them, for example after an upset, the next-state function sends it to 0 on the next clock edge, so the counter re-enters the ring in a single cycle. A synchronous reset also sends the counter to 0.

A parameter chooses how the excitation stage fills the don't-care J or K input. With one setting those inputs are held low. With the other they are held high, which makes the stage toggle. Both settings must give the same count sequence.

Top module: `seqc_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` becomes 0 after that edge, from any prior value.
- R2: From value 0, the next rising edge with `rst` low gives value 3.
- R3: From value 3, the next edge gives value 5.
- R4: From value 5, the next edge gives value 7.
- R5: From value 7, the next edge gives value 6.
- R6: From value 6, the next edge gives value 0, which closes the ring.
- R7: From any unused value (1, 2 or 4), the next edge with `rst` low gives value 0.
- R8: Each state bit behaves as a JK stage on every edge with `rst` low. J=0 and K=0 hold the bit. J=0 and K=1 clear it. J=1 and K=0 set it. J=1 and K=1 invert it.
- R9: Both settings of `JK_FILL` (0 holds the don't-care inputs low, 1 holds them high) produce the same value sequence, including recovery from unused values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| count | output | 3 | Current counter value |

## Verification
The bench builds the counter twice, side by side. One copy uses `JK_FILL`=0 and the other uses `JK_FILL`=1. Between them, the set, clear, hold and toggle paths of every JK stage are exercised, and any difference between the two settings shows up directly at the outputs.

The bench forces the stage registers of both copies to each unused value in the same cycle that reset is released. This reaches the recovery path from 1, 2 and 4, which normal counting never visits.

// File: rtl/seqc_pkg.sv
package seqc_pkg;
  localparam int CNT_W = 3;
  typedef logic [CNT_W-1:0] cnt_t;

  // Successor of a value on the ring; values outside the ring return to 0
  function automatic cnt_t seq_next(input cnt_t cur);
    case (cur)
      3'd0:    return 3'd3;
      3'd3:    return 3'd5;
      3'd5:    return 3'd7;
      3'd7:    return 3'd6;
      3'd6:    return 3'd0;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic on_ring(input cnt_t cur);
    return (cur == 3'd0) || (cur == 3'd3) || (cur == 3'd5) ||
           (cur == 3'd7) || (cur == 3'd6);
  endfunction

  // Next value of one JK bit
  function automatic logic jk_apply(input logic q, input logic j, input logic k);
    case ({j, k})
      2'b00:   return q;
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return ~q;
    endcase
  endfunction
endpackage

// File: rtl/seqc_next.sv
module seqc_next
  import seqc_pkg::*;
(
  input  logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] tgt,
  output logic             valid
);
  always_comb begin
    tgt   = seq_next(cur);
    valid = on_ring(cur);
  end
endmodule

// File: rtl/seqc_jk_excite.sv
module seqc_jk_excite #(
  parameter int JK_FILL = 0
) (
  input  logic cur,
  input  logic tgt,
  output logic j,
  output logic k
);
  generate
    if (JK_FILL == 0) begin : g_low
      // don't-care inputs held low: set and clear only
      always_comb begin
        j = ~cur & tgt;
        k = cur & ~tgt;
      end
    end else begin : g_high
      // don't-care inputs held high: toggle where allowed
      always_comb begin
        j = cur | tgt;
        k = ~cur | ~tgt;
      end
    end
  endgenerate
endmodule

// File: rtl/seqc_jk_stage.sv
module seqc_jk_stage
  import seqc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  logic q_r;

  always_ff @(posedge clk) begin
    if (rst) q_r <= 1'b0;
    else     q_r <= jk_apply(q_r, j, k);
  end

  assign q = q_r;
endmodule

// File: rtl/seqc_counter.sv
module seqc_counter
  import seqc_pkg::*;
#(
  parameter int JK_FILL = 0
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cur_val;
  logic [CNT_W-1:0] nxt_val;
  logic             cur_on_ring;
  logic [CNT_W-1:0] j_vec;
  logic [CNT_W-1:0] k_vec;

  seqc_next u_next (
    .cur   (cur_val),
    .tgt   (nxt_val),
    .valid (cur_on_ring)
  );

  for (genvar b = 0; b < CNT_W; b++) begin : g_stage
    seqc_jk_excite #(.JK_FILL(JK_FILL)) u_exc (
      .cur (cur_val[b]),
      .tgt (nxt_val[b]),
      .j   (j_vec[b]),
      .k   (k_vec[b])
    );
    seqc_jk_stage u_jk (
      .clk (clk),
      .rst (rst),
      .j   (j_vec[b]),
      .k   (k_vec[b]),
      .q   (cur_val[b])
    );
  end

  assign count = cur_val;
endmodule

// File: rtl/seqc_counter_chk.sv
module seqc_counter_chk
  import seqc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] nxt,
  input logic             ring_ok,
  input logic [CNT_W-1:0] j_vec,
  input logic [CNT_W-1:0] k_vec
);
  // R2
  s0_to_s3_chk: assert property (@(posedge clk) disable iff (rst)
    (count == 3'd0) |-> (nxt == 3'd3));
  // R3
  s3_to_s5_chk: assert property (@(posedge clk) disable iff (rst)
    (count == 3'd3) |-> (nxt == 3'd5));
  // R4
  s5_to_s7_chk: assert property (@(posedge clk) disable iff (rst)
    (count == 3'd5) |-> (nxt == 3'd7));
  // R5
  s7_to_s6_chk: assert property (@(posedge clk) disable iff (rst)
    (count == 3'd7) |-> (nxt == 3'd6));
  // R6
  s6_to_s0_chk: assert property (@(posedge clk) disable iff (rst)
    (count == 3'd6) |-> (nxt == 3'd0));
  // R7
  unused_recover_chk: assert property (@(posedge clk) disable iff (rst)
    !ring_ok |-> (nxt == 3'd0));

  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    // R8
    jk_stage_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (count[b] == ($past(j_vec[b]) & $past(k_vec[b]) ? ~$past(count[b]) :
                             $past(j_vec[b]) ? 1'b1 :
                             $past(k_vec[b]) ? 1'b0 : $past(count[b]))));
  end
endmodule

bind seqc_counter seqc_counter_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .count   (count),
  .nxt     (nxt_val),
  .ring_ok (cur_on_ring),
  .j_vec   (j_vec),
  .k_vec   (k_vec)
);

// File: tb/sim_seqc_counter.sv
module sim_seqc_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cnt0;
  logic [2:0] cnt1;
  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] frc_v;

  always #2.5 clk = ~clk;

  seqc_counter #(.JK_FILL(0)) u0 (.clk(clk), .rst(rst), .count(cnt0));
  seqc_counter #(.JK_FILL(1)) u1 (.clk(clk), .rst(rst), .count(cnt1));

  // each entry: {rst, expected value after the edge}
  localparam int NV = 16;
  localparam logic [3:0] VEC [NV] = '{
    4'b1_000, 4'b0_011, 4'b0_101, 4'b0_111, 4'b0_110, 4'b0_000,
    4'b0_011, 4'b0_101, 4'b0_111, 4'b0_110, 4'b0_000, 4'b0_011,
    4'b0_101, 4'b1_000, 4'b0_011, 4'b0_101};

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic r, input logic [2:0] prev);
    if (r) return "R1";
    case (prev)
      3'd0: return "R2";
      3'd3: return "R3";
      3'd5: return "R4";
      3'd7: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin : watchdog
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [2:0] prev;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", cnt0, 3'd0);
    check("R9", cnt1, 3'd0);
    prev = 3'd0;
    // table walk: two full rings (R2..R6), a mid-run reset (R1), R8 via bit transitions
    for (int i = 0; i < NV; i++) begin
      rst = VEC[i][3];
      @(posedge clk);
      @(negedge clk);
      check(req_of(VEC[i][3], prev), cnt0, VEC[i][2:0]);
      check("R8", cnt0, VEC[i][2:0]);
      check("R9", cnt1, VEC[i][2:0]);
      prev = VEC[i][2:0];
    end
    // reset from a nonzero value (R1)
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", cnt0, 3'd0);
    check("R1", cnt1, 3'd0);
    // unused values: force stage registers as reset releases (R7)
    for (int u = 0; u < 3; u++) begin
      frc_v = 3'd1 << u;
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      force u0.g_stage[0].u_jk.q_r = frc_v[0];
      force u0.g_stage[1].u_jk.q_r = frc_v[1];
      force u0.g_stage[2].u_jk.q_r = frc_v[2];
      force u1.g_stage[0].u_jk.q_r = frc_v[0];
      force u1.g_stage[1].u_jk.q_r = frc_v[1];
      force u1.g_stage[2].u_jk.q_r = frc_v[2];
      #0.5;
      release u0.g_stage[0].u_jk.q_r;
      release u0.g_stage[1].u_jk.q_r;
      release u0.g_stage[2].u_jk.q_r;
      release u1.g_stage[0].u_jk.q_r;
      release u1.g_stage[1].u_jk.q_r;
      release u1.g_stage[2].u_jk.q_r;
      #0.5;
      check("R7", cnt0, frc_v);
      @(posedge clk); @(negedge clk);
      check("R7", cnt0, 3'd0);
      check("R9", cnt1, 3'd0);
      @(posedge clk); @(negedge clk);
      check("R2", cnt0, 3'd3);
      check("R9", cnt1, 3'd3);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule